// File: doc/BRIEF.md
# Double-Data-Rate Output Serializer

This block turns a stream of word pairs, one pair per slow clock cycle, into a single output line that carries two words per cycle. The first word of each pair is on the line while the slow clock is high. The second word is on the line while the clock is low. A rising-edge register stage captures both words of the pair. A falling-edge register re-times the second word so that it stays steady through the low half of the cycle. A multiplexer steered by the clock level then picks which register drives the line.

A synchronous active-high reset loads a single reset word into the whole path. The line therefore shows that word in both halves of every cycle whose rising edge saw reset. A pair offered at a reset edge is discarded. A clock enable gates the capture. While it is low the captured pair is kept, so the line repeats the last pair. The latency is one rising edge: a pair sampled at a rising edge appears during the high and low phases that follow that edge.

Top module: `ddr_serializer`

## Requirements
- R1: At a rising edge where `rst` is 1, both captured words are replaced by `rst_val`. In the high phase and the low phase that follow that edge, `ddr_q` equals that `rst_val`. The pair on the inputs at that edge never appears.
- R2: At a rising edge where `rst` is 0 and `en` is 1, `ddr_q` shows `word_first` as sampled at that edge for the whole high phase that follows.
- R3: After the same edge, `ddr_q` shows `word_second` as sampled at that edge for the whole low phase that follows.
- R4: At a rising edge where `rst` is 0 and `en` is 0, the captured pair is kept unchanged. Both phases that follow repeat the words of the previous cycle, whatever values sit on the word inputs.
- R5: Reset takes priority over the enable: a rising edge with `rst` at 1 loads `rst_val` even when `en` is 0.
- R6: The line changes at twice the slow rate. Within one cycle, the high-phase word comes from the first element of a pair and the low-phase word from the second element of the same pair, never the other way round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock; its level also selects the output half |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for the capture registers |
| rst_val | input | WIDTH | Word driven on the line while reset is in effect |
| word_first | input | WIDTH | First element of the pair, sent in the high phase |
| word_second | input | WIDTH | Second element of the pair, sent in the low phase |
| ddr_q | output | WIDTH | Double-data-rate output line |

## Verification
On every cycle, assertions check four things: the reset load, capture under enable, the hold when the enable is low, and that the falling-edge stage tracks the captured second word. Separate checks at each clock edge confirm that the line shows the first-word register during the high phase and the re-timed second word during the low phase. Only the bench's scenarios show the complete half-cycle sequence on the line. These include the run of reset words, the loss of a pair offered during reset, and repeated pairs during enable gaps. They also show that a changing reset word and a reset raised in mid-stream produce the right words in each half.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;

  typedef enum logic {
    HALF_LOW  = 1'b0,
    HALF_HIGH = 1'b1
  } half_e;

  function automatic half_e half_of(input logic level);
    return level ? HALF_HIGH : HALF_LOW;
  endfunction

endpackage

// File: rtl/ddr_pos_capture.sv
module ddr_pos_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] rst_val,
  input  logic [WIDTH-1:0] in_first,
  input  logic [WIDTH-1:0] in_second,
  output logic [WIDTH-1:0] first_q,
  output logic [WIDTH-1:0] second_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q  <= rst_val;
      second_q <= rst_val;
    end else if (en) begin
      first_q  <= in_first;
      second_q <= in_second;
    end
  end

  // R1 / R5: a reset edge loads the reset word whatever the enable is
  p_reset_load_r1: assert property (@(posedge clk)
    rst |=> (first_q == $past(rst_val)) && (second_q == $past(rst_val)));

  // R2 / R3: an enabled edge captures both words of the pair
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && en) |=> (first_q == $past(in_first)) && (second_q == $past(in_second)));

  // R4: a disabled edge keeps the pair
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(first_q) && $stable(second_q));

endmodule

// File: rtl/ddr_neg_stage.sv
module ddr_neg_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(negedge clk) begin
    q <= d;
  end

endmodule

// File: rtl/ddr_phase_mux.sv
module ddr_phase_mux
  import ddr_ser_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] high_word,
  input  logic [WIDTH-1:0] low_word,
  output logic [WIDTH-1:0] line
);

  half_e half;

  always_comb begin
    half = half_of(clk);
    case (half)
      HALF_HIGH: line = high_word;
      default:   line = low_word;
    endcase
  end

endmodule

// File: rtl/ddr_serializer.sv
module ddr_serializer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] rst_val,
  input  logic [WIDTH-1:0] word_first,
  input  logic [WIDTH-1:0] word_second,
  output logic [WIDTH-1:0] ddr_q
);

  logic [WIDTH-1:0] cap_first;
  logic [WIDTH-1:0] cap_second;
  logic [WIDTH-1:0] late_second;

  ddr_pos_capture #(.WIDTH(WIDTH)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .rst_val   (rst_val),
    .in_first  (word_first),
    .in_second (word_second),
    .first_q   (cap_first),
    .second_q  (cap_second)
  );

  ddr_neg_stage #(.WIDTH(WIDTH)) u_retime (
    .clk (clk),
    .d   (cap_second),
    .q   (late_second)
  );

  ddr_phase_mux #(.WIDTH(WIDTH)) u_mux (
    .clk       (clk),
    .high_word (cap_first),
    .low_word  (late_second),
    .line      (ddr_q)
  );

  // R3: at each rising edge the re-timed word matches the captured second word
  p_retime_follow_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> late_second == cap_second);

  // R6: just before a falling edge the line carries the first-word register
  p_high_half_r6: assert property (@(negedge clk) disable iff (rst)
    ddr_q == cap_first);

  // R6: just before a rising edge the line carries the re-timed second word
  p_low_half_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ddr_q == late_second);

endmodule

// File: tb/ddr_serializer_tb.sv
module ddr_serializer_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [W-1:0] rst_val = '0;
  logic [W-1:0] word_first = '0;
  logic [W-1:0] word_second = '0;
  logic [W-1:0] ddr_q;

  int n_checks = 0;
  int n_fail = 0;
  logic [W-1:0] exp_hi;
  logic [W-1:0] exp_lo;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ddr_serializer #(.WIDTH(W)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .rst_val     (rst_val),
    .word_first  (word_first),
    .word_second (word_second),
    .ddr_q       (ddr_q)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ddr_q=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One slow cycle: inputs are set in the low phase, the model updates at the
  // rising edge, then the high and low halves are each sampled mid-phase.
  task automatic cycle(input logic r, input logic e, input logic [W-1:0] rv,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input string req_hi, input string req_lo);
    rst = r; en = e; rst_val = rv; word_first = a; word_second = b;
    @(posedge clk);
    if (r) begin
      exp_hi = rv; exp_lo = rv;
    end else if (e) begin
      exp_hi = a; exp_lo = b;
    end
    #2.5;
    check(req_hi, ddr_q, exp_hi);
    @(negedge clk);
    #2.5;
    check(req_lo, ddr_q, exp_lo);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset run, pair offered during reset is lost
    cycle(1, 1, 8'hFF, 8'd0, 8'd1, "R1", "R1");
    cycle(1, 1, 8'hFF, 8'd0, 8'd1, "R1", "R1");
    // R2 R3: stream of pairs right after release
    cycle(0, 1, 8'hFF, 8'd2, 8'd3, "R2", "R3");
    cycle(0, 1, 8'hFF, 8'd4, 8'd5, "R2", "R3");
    // R2 R3 R6: sweep of distinct word patterns, both halves differ
    for (int k = 0; k < 64; k++) begin
      cycle(0, 1, 8'h00, W'(k * 7 + 3), W'(255 - k * 5), "R2", "R6");
    end
    // R4: enable low, inputs change but the line repeats the last pair
    for (int k = 0; k < 8; k++) begin
      cycle(0, 0, 8'h00, W'(k + 100), W'(k + 200), "R4", "R4");
    end
    // R4 / R2: alternating enable
    for (int k = 0; k < 32; k++) begin
      cycle(0, (k % 2) == 0, 8'h00, W'(k * 11), W'(k * 3 + 1), "R4", "R3");
    end
    // R5: reset in mid-stream with enable low, varying reset word
    for (int k = 0; k < 4; k++) begin
      cycle(1, 0, W'(k * 40 + 9), 8'hAA, 8'h55, "R5", "R5");
    end
    // R1: reset held with enable high and changing reset words
    for (int k = 0; k < 4; k++) begin
      cycle(1, 1, W'(k * 17 + 2), W'(k), W'(k + 1), "R1", "R1");
    end
    // R2 R3: recovery after reset; first and second swapped patterns
    for (int k = 0; k < 16; k++) begin
      cycle(0, 1, 8'h00, W'(255 - k), W'(k), "R2", "R3");
    end
    done = 1'b1;
    finish_run();
  end

endmodule